// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This block sits between an internal clocked request bus and an external asynchronous static RAM of 262,144 words by 16 bits. It takes one single-word read or write at a time and turns it into a pin-level cycle on the memory: an 18-bit address, active-low chip select, write strobe and output strobe, and two active-low byte-lane enables. The memory's bidirectional data bus is reached through a separate drive-enable, data-out and data-in triple, so the pad itself stays outside the block.

Every access runs through the phases IDLE, SETUP, ACCESS, HOLD and DONE. The number of clocks spent in ACCESS is the parameter `WAIT_CYC`, which is chosen so that the strobe-low window covers the memory's 12 ns access time at the system clock. A byte mask picks the low lane (data bits 7:0) and the high lane (bits 15:8) independently. The chip is deselected whenever no access is in flight, which lets the memory fall into its automatic low-power state.

The request side is valid/ready. `req_ready` is high only while the controller is idle. A request moves when `req_valid` and `req_ready` are both high at a rising clock edge, and its fields are captured at that edge. A source that sees `req_ready` low must hold `req_valid` and its fields until it is accepted. The controller never stalls its response: `rsp_done` and `rsp_rdata_valid` are single-cycle pulses with no ready signal coming back.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11, `dq_oe` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only in the idle phase. A request is taken when `req_valid` and `req_ready` are both 1 at a rising edge. A request held valid while the controller is busy waits, and it is carried out with the field values present at its acceptance.
- R3: A write with a non-zero mask holds `mem_ce_n` and `mem_we_n` low together for exactly `WAIT_CYC` cycles. `req_mask[0]` selects the low lane (bits 7:0), driven as `mem_be_n[0]`=0, and `req_mask[1]` selects the high lane (bits 15:8), driven as `mem_be_n[1]`=0. Only the selected bytes of the addressed word change.
- R4: During a write, chip select, address and byte enables are valid one cycle before `mem_we_n` falls and are still held in the cycle after it rises. `dq_oe` is 1 and `dq_out` is stable for the whole strobe-low interval.
- R5: A read with a non-zero mask holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for exactly `WAIT_CYC` cycles, and samples `dq_in` in the last of those cycles. `rsp_rdata` then carries the selected lanes, with unselected lanes reading as zero.
- R6: `dq_oe` is 0 in every cycle where `mem_oe_n` is 0, and it is 0 in the cycle just before `mem_oe_n` falls.
- R7: `mem_we_n` and `mem_oe_n` are never both low.
- R8: `mem_ce_n` is 1 whenever no access is in its SETUP, ACCESS or HOLD phase, including the DONE cycle.
- R9: A request with mask 2'b00 asserts neither chip select, write strobe nor output strobe. It still pulses `rsp_done` in the cycle after acceptance, and as a read it pulses `rsp_rdata_valid` with `rsp_rdata` = 0.
- R10: For a non-zero mask, `rsp_done` is high for one cycle, namely the (`WAIT_CYC`+3)th cycle after the accepting edge. `rsp_rdata_valid` pulses in that same cycle for reads only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle; can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_rdata | output | 16 | Read data, valid with rsp_rdata_valid |
| rsp_rdata_valid | output | 1 | One-cycle read result pulse |
| rsp_done | output | 1 | One-cycle completion pulse for every request |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low (bit 0 low lane) |
| dq_oe | output | 1 | Controller drives the data bus |
| dq_out | output | 16 | Data toward the memory |
| dq_in | input | 16 | Data from the memory |

## Verification
Writes and reads are tried with the full mask, with each single lane and with an empty mask. A low-lane write over a known word tells a correct lane merge apart from a whole-word write, a high-lane read tells lane masking of the result apart from passing the bus through, and empty-mask requests tell a skipped cycle apart from one that still strobes the memory. A request held valid across a busy controller tells true back-pressure apart from sampling fields late or losing the request. A bus monitor counts strobe cycles, drive overlaps and setup/hold violations for every access pattern.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACCESS = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_t;

endpackage

// File: rtl/asram_wait_ctr.sv
module asram_wait_ctr #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic last
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] START = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= START;
    end else if (run && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == '0);

  AST_CTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= START);  // R3
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   req_any_lane,
  input  logic   wait_last,
  output phase_t phase,
  output logic   accept,
  output logic   ctr_load,
  output logic   ctr_run
);
  phase_t phase_nxt;

  assign accept   = (phase == PH_IDLE) && req_valid;
  assign ctr_load = (phase == PH_SETUP);
  assign ctr_run  = (phase == PH_ACCESS);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:   if (accept) phase_nxt = req_any_lane ? PH_SETUP : PH_DONE;
      PH_SETUP:  phase_nxt = PH_ACCESS;
      PH_ACCESS: if (wait_last) phase_nxt = PH_HOLD;
      PH_HOLD:   phase_nxt = PH_DONE;
      PH_DONE:   phase_nxt = PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nxt;
  end

  AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE) |=> (phase == PH_IDLE));  // R10
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> (phase != PH_SETUP) || ($past(phase) == PH_IDLE));  // R2
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic              accept,
  input  logic              wait_last,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_rdata_valid,
  output logic              rsp_done
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [LANES-1:0]  mask_q;
  logic              wr_q;
  logic [DATA_W-1:0] lane_bits;
  logic              busy;
  logic              strobe;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g*8 +: 8] = {8{mask_q[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
      wr_q    <= req_write;
      rdata_q <= '0;
    end else if (phase == PH_ACCESS && !wr_q && wait_last) begin
      rdata_q <= dq_in & lane_bits;
    end
  end

  assign busy   = (phase == PH_SETUP) || (phase == PH_ACCESS) || (phase == PH_HOLD);
  assign strobe = (phase == PH_ACCESS);

  assign mem_addr        = addr_q;
  assign mem_ce_n        = !busy;
  assign mem_we_n        = !(strobe && wr_q);
  assign mem_oe_n        = !(strobe && !wr_q);
  assign mem_be_n        = busy ? ~mask_q : '1;
  assign dq_oe           = busy && wr_q;
  assign dq_out          = wdata_q;
  assign rsp_done        = (phase == PH_DONE);
  assign rsp_rdata_valid = rsp_done && !wr_q;
  assign rsp_rdata       = rdata_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));  // R7
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(dq_oe && !mem_oe_n));  // R6
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> $past(!dq_oe));  // R6
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr) && $stable(mem_be_n)));  // R4
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && dq_oe && $stable(mem_addr) && $stable(mem_be_n)));  // R4
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(dq_out) && dq_oe));  // R4
  AST_DESELECT_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> mem_ce_n);  // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_rdata_valid |=> !rsp_rdata_valid);  // R10
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 2,
  localparam int LANES   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_rdata_valid,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  input  logic [DATA_W-1:0] dq_in
);
  phase_t phase;
  logic   accept;
  logic   ctr_load;
  logic   ctr_run;
  logic   wait_last;

  assign req_ready = (phase == PH_IDLE);

  asram_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_any_lane (|req_mask),
    .wait_last    (wait_last),
    .phase        (phase),
    .accept       (accept),
    .ctr_load     (ctr_load),
    .ctr_run      (ctr_run)
  );

  asram_wait_ctr #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk  (clk),
    .rst  (rst),
    .load (ctr_load),
    .run  (ctr_run),
    .last (wait_last)
  );

  asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
    .clk             (clk),
    .rst             (rst),
    .phase           (phase),
    .accept          (accept),
    .wait_last       (wait_last),
    .req_write       (req_write),
    .req_addr        (req_addr),
    .req_wdata       (req_wdata),
    .req_mask        (req_mask),
    .dq_in           (dq_in),
    .mem_addr        (mem_addr),
    .mem_ce_n        (mem_ce_n),
    .mem_we_n        (mem_we_n),
    .mem_oe_n        (mem_oe_n),
    .mem_be_n        (mem_be_n),
    .dq_oe           (dq_oe),
    .dq_out          (dq_out),
    .rsp_rdata       (rsp_rdata),
    .rsp_rdata_valid (rsp_rdata_valid),
    .rsp_done        (rsp_done)
  );

  AST_READY_IDLE_DESELECT: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !dq_oe));  // R8
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);  // R2
endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  localparam int W = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_rdata_valid;
  logic        rsp_done;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n;
  logic        dq_oe;
  logic [15:0] dq_out;
  logic [15:0] dq_in;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] mem [256];
  int we_cyc = 0, oe_cyc = 0, ce_cyc = 0, clash = 0, overlap = 0, r4_err = 0;
  logic prev_we = 1'b1, prev_ce = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
  logic [15:0] prev_dq = '0;
  logic [17:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  asram_ctrl #(.WAIT_CYC(W)) i_asram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_rdata(rsp_rdata), .rsp_rdata_valid(rsp_rdata_valid),
    .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in)
  );

  // memory model: unselected lanes float to a junk pattern
  always_comb begin
    dq_in = 16'hEEEE;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_be_n[0]) dq_in[7:0]  = mem[mem_addr[7:0]][7:0];
      if (!mem_be_n[1]) dq_in[15:8] = mem[mem_addr[7:0]][15:8];
    end
  end

  always @(posedge mem_we_n) begin
    if (!mem_ce_n && dq_oe) begin
      if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  <= dq_out[7:0];
      if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] <= dq_out[15:8];
    end
  end

  // bus monitor sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_we_n) we_cyc++;
      if (!mem_oe_n) oe_cyc++;
      if (!mem_ce_n) ce_cyc++;
      if (dq_oe && !mem_oe_n) clash++;
      if (!mem_oe_n && prev_oe && prev_dqoe) clash++;
      if (!mem_we_n && !mem_oe_n) overlap++;
      if (!mem_we_n && prev_we && prev_ce) r4_err++;
      if (mem_we_n && !prev_we && (mem_ce_n || mem_addr != prev_addr || !dq_oe)) r4_err++;
      if (!mem_we_n && !prev_we && (dq_out != prev_dq || !dq_oe)) r4_err++;
    end
    prev_we = mem_we_n; prev_ce = mem_ce_n; prev_oe = mem_oe_n;
    prev_dqoe = dq_oe; prev_dq = dq_out; prev_addr = mem_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, output logic [15:0] rd,
                       output bit rv, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_done && lat < 50);
    rd = rsp_rdata; rv = rsp_rdata_valid;
  endtask

  task automatic t_reset();
    chk("R1 ce_n", mem_ce_n, 1); chk("R1 we_n", mem_we_n, 1);
    chk("R1 oe_n", mem_oe_n, 1); chk("R1 be_n", mem_be_n, 2'b11);
    chk("R1 dq_oe", dq_oe, 0);  chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_full_word();
    logic [15:0] rd; bit rv; int lat; int w0, o0;
    w0 = we_cyc;
    issue(1, 18'h00012, 16'hA55A, 2'b11, rd, rv, lat);
    chk("R3 we cycles", we_cyc - w0, W);
    chk("R10 write latency", lat, W + 3);
    chk("R10 no rvalid on write", rv, 0);
    chk("R8 ce_n high in done", mem_ce_n, 1);
    chk("R3 stored word", mem[8'h12], 16'hA55A);
    o0 = oe_cyc;
    issue(0, 18'h00012, 16'h0, 2'b11, rd, rv, lat);
    chk("R5 oe cycles", oe_cyc - o0, W);
    chk("R5 read data", rd, 16'hA55A);
    chk("R10 read latency", lat, W + 3);
    chk("R10 rvalid", rv, 1);
    @(negedge clk);
    chk("R10 rvalid one pulse", rsp_rdata_valid, 0);
  endtask

  task automatic t_lanes();
    logic [15:0] rd; bit rv; int lat;
    issue(1, 18'h00034, 16'h1122, 2'b11, rd, rv, lat);
    issue(1, 18'h00034, 16'hFF99, 2'b01, rd, rv, lat);
    chk("R3 low lane only", mem[8'h34], 16'h1199);
    issue(1, 18'h00034, 16'h77FF, 2'b10, rd, rv, lat);
    chk("R3 high lane only", mem[8'h34], 16'h7799);
    issue(0, 18'h00034, 16'h0, 2'b10, rd, rv, lat);
    chk("R5 high lane read, low zero", rd, 16'h7700);
    issue(0, 18'h00034, 16'h0, 2'b01, rd, rv, lat);
    chk("R5 low lane read, high zero", rd, 16'h0099);
  endtask

  task automatic t_empty_mask();
    logic [15:0] rd; bit rv; int lat; int c0, w0, o0;
    c0 = ce_cyc; w0 = we_cyc; o0 = oe_cyc;
    issue(1, 18'h00034, 16'h0000, 2'b00, rd, rv, lat);
    chk("R9 write latency", lat, 1);
    chk("R9 word unchanged", mem[8'h34], 16'h7799);
    issue(0, 18'h00034, 16'h0000, 2'b00, rd, rv, lat);
    chk("R9 read rvalid", rv, 1);
    chk("R9 read zero", rd, 16'h0000);
    chk("R9 no ce", ce_cyc - c0, 0);
    chk("R9 no we", we_cyc - w0, 0);
    chk("R9 no oe", oe_cyc - o0, 0);
  endtask

  task automatic t_backpressure();
    logic [15:0] rd; bit rv; int lat; int busy_ready;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00050; req_wdata = 16'hBEEF; req_mask = 2'b11;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_addr = 18'h00051; req_wdata = 16'hCAFE;
    busy_ready = 0;
    do begin @(negedge clk); if (req_ready) busy_ready++; end while (!rsp_done);
    chk("R2 ready low while busy", busy_ready, 0);
    @(negedge clk);
    chk("R2 ready back in idle", req_ready, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_done && lat < 50);
    chk("R2 first request fields", mem[8'h50], 16'hBEEF);
    chk("R2 held request done", mem[8'h51], 16'hCAFE);
    issue(0, 18'h00051, 16'h0, 2'b11, rd, rv, lat);
    chk("R2 held request readback", rd, 16'hCAFE);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_lanes();
    t_empty_mask();
    t_backpressure();
    repeat (3) @(negedge clk);
    chk("R6 bus contention", clash, 0);
    chk("R7 strobe overlap", overlap, 0);
    chk("R4 write setup/hold", r4_err, 0);
    chk("R8 idle ce_n", mem_ce_n, 1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule